// File: doc/BRIEF.md
# Split Wide Multiplier Composer

This block forms an unsigned AW×BW product from four narrower multipliers. Each narrower multiplier stands in for a fixed hard multiplier with port widths A0W and B0W. Each operand is cut into a low part and a high part. The four cross products of those parts are placed at their binary weights and added together. The result is truncated to AW+BW bits.

Two adder layouts exist, and the parameters choose one at elaboration. When the low-part widths match, the lowest bits of the result come straight from the low×low product. The middle cross terms are summed with a kept carry and then added to the rest. When the widths differ, the two cross terms are summed at their shifted positions, and the high×high and low×low products are joined side by side. A last add combines the two, and any carry past the output is dropped. If operand A is narrower than operand B while A0W is greater than B0W, the two port widths swap roles, so that the wider port goes to the B operand. The block is purely combinational.

Top module: `split_mul_composer`

## Requirements
- R1: `prod_o` equals the unsigned product of `a_i` and `b_i`, as a full AW+BW-bit value, for every input pair.
- R2: A is cut at bit EA and B at bit EB. EA and EB are the effective port widths, A0W and B0W unless R6 swaps them. Operands with a single set bit at the cut positions (A = 2^EA, B = 2^EB) and one below them give exact products.
- R3: With EA equal to EB, bits [EB-1:0] of `prod_o` equal the low EB bits of (a_i mod 2^EA)·(b_i mod 2^EB).
- R4: With EA equal to EB, all-ones operands, where every intermediate add carries, give (2^AW−1)(2^BW−1).
- R5: With EA different from EB, all-ones operands give (2^AW−1)(2^BW−1), and the final carry beyond AW+BW bits is dropped.
- R6: When AW < BW and A0W > B0W, EA takes B0W and EB takes A0W. The product is still exact.
- R7: A zero on either operand gives an all-zero `prod_o`.
- R8: `prod_o` reflects a new input pair within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | AW | Unsigned multiplicand |
| b_i | input | BW | Unsigned multiplier |
| prod_o | output | AW+BW | Unsigned product |

## Verification
Nothing in this block holds state, so a wrong internal term shows up on `prod_o` in the same cycle as the inputs that expose it. A bad cut position or a misplaced shift corrupts products whose operands have bits on both sides of the cut. A lost carry appears only when the cross terms overflow, which all-ones operands force. Three instances check the equal-width layout, the unequal-width layout and the swapped-port layout against a direct product, and the comparison is made every cycle.

// File: rtl/split_mul_pkg.sv
package split_mul_pkg;
  function automatic bit port_swap(int aw, int bw, int a0w, int b0w);
    return (aw < bw) && (a0w > b0w);
  endfunction

  function automatic int eff_lo_a(int aw, int bw, int a0w, int b0w);
    return port_swap(aw, bw, a0w, b0w) ? b0w : a0w;
  endfunction

  function automatic int eff_lo_b(int aw, int bw, int a0w, int b0w);
    return port_swap(aw, bw, a0w, b0w) ? a0w : b0w;
  endfunction

  function automatic int max2(int x, int y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/sub_mul.sv
module sub_mul #(
  parameter int XW = 8,
  parameter int YW = 8,
  localparam int PW = XW + YW
) (
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  output logic [PW-1:0] p_o
);
  assign p_o = PW'(x_i) * PW'(y_i);
endmodule

// File: rtl/split_add_eq.sv
module split_add_eq #(
  parameter int K   = 8,
  parameter int A1W = 8,
  parameter int B1W = 8,
  localparam int PW = 2*K + A1W + B1W,
  localparam int UW = PW - K,
  localparam int SW = split_mul_pkg::max2(A1W + K, K + B1W) + 1
) (
  input  logic [2*K-1:0]     p00_i,
  input  logic [K+B1W-1:0]   p01_i,
  input  logic [A1W+K-1:0]   p10_i,
  input  logic [A1W+B1W-1:0] p11_i,
  output logic [PW-1:0]      prod_o
);
  logic [SW-1:0] cross_sum;
  logic [UW-1:0] upper_op;
  logic [UW-1:0] upper_sum;

  // cross terms share weight 2^K; keep the carry
  assign cross_sum = SW'(p10_i) + SW'(p01_i);
  assign upper_op  = {p11_i, p00_i[2*K-1:K]};
  assign upper_sum = UW'(cross_sum) + upper_op;
  assign prod_o    = {upper_sum, p00_i[K-1:0]};
endmodule

// File: rtl/split_add_ne.sv
module split_add_ne #(
  parameter int EA  = 9,
  parameter int EB  = 5,
  parameter int A1W = 7,
  parameter int B1W = 7,
  localparam int PW = EA + EB + A1W + B1W
) (
  input  logic [EA+EB-1:0]   p00_i,
  input  logic [EA+B1W-1:0]  p01_i,
  input  logic [A1W+EB-1:0]  p10_i,
  input  logic [A1W+B1W-1:0] p11_i,
  output logic [PW-1:0]      prod_o
);
  logic [PW-1:0] cross_sum;
  logic [PW-1:0] outer_join;

  assign cross_sum  = (PW'(p10_i) << EA) + (PW'(p01_i) << EB);
  // high*high and low*low never overlap
  assign outer_join = {p11_i, p00_i};
  // carry past PW drops
  assign prod_o     = cross_sum + outer_join;
endmodule

// File: rtl/split_mul_composer.sv
module split_mul_composer #(
  parameter int AW  = 16,
  parameter int BW  = 16,
  parameter int A0W = 8,
  parameter int B0W = 8,
  localparam int PW  = AW + BW,
  localparam int EA  = split_mul_pkg::eff_lo_a(AW, BW, A0W, B0W),
  localparam int EB  = split_mul_pkg::eff_lo_b(AW, BW, A0W, B0W),
  localparam int A1W = AW - EA,
  localparam int B1W = BW - EB
) (
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [PW-1:0] prod_o
);
  logic [EA-1:0]  a_lo;
  logic [A1W-1:0] a_hi;
  logic [EB-1:0]  b_lo;
  logic [B1W-1:0] b_hi;

  logic [EA+EB-1:0]   p00;
  logic [EA+B1W-1:0]  p01;
  logic [A1W+EB-1:0]  p10;
  logic [A1W+B1W-1:0] p11;

  assign a_lo = a_i[EA-1:0];
  assign a_hi = a_i[AW-1:EA];
  assign b_lo = b_i[EB-1:0];
  assign b_hi = b_i[BW-1:EB];

  sub_mul #(.XW(EA),  .YW(EB))  u_m00 (.x_i(a_lo), .y_i(b_lo), .p_o(p00));
  sub_mul #(.XW(EA),  .YW(B1W)) u_m01 (.x_i(a_lo), .y_i(b_hi), .p_o(p01));
  sub_mul #(.XW(A1W), .YW(EB))  u_m10 (.x_i(a_hi), .y_i(b_lo), .p_o(p10));
  sub_mul #(.XW(A1W), .YW(B1W)) u_m11 (.x_i(a_hi), .y_i(b_hi), .p_o(p11));

  generate
    if (EA == EB) begin : g_eq
      split_add_eq #(.K(EA), .A1W(A1W), .B1W(B1W)) u_add (
        .p00_i(p00), .p01_i(p01), .p10_i(p10), .p11_i(p11), .prod_o(prod_o)
      );
    end else begin : g_ne
      split_add_ne #(.EA(EA), .EB(EB), .A1W(A1W), .B1W(B1W)) u_add (
        .p00_i(p00), .p01_i(p01), .p10_i(p10), .p11_i(p11), .prod_o(prod_o)
      );
    end
  endgenerate
endmodule

// File: rtl/split_mul_chk.sv
module split_mul_chk #(
  parameter int AW  = 16,
  parameter int BW  = 16,
  parameter int A0W = 8,
  parameter int B0W = 8,
  localparam int PW = AW + BW,
  localparam int EA = split_mul_pkg::eff_lo_a(AW, BW, A0W, B0W),
  localparam int EB = split_mul_pkg::eff_lo_b(AW, BW, A0W, B0W)
) (
  input logic [AW-1:0] a_i,
  input logic [BW-1:0] b_i,
  input logic [PW-1:0] prod_o
);
  logic [PW-1:0]    ones_val;
  logic [EA+EB-1:0] lo_prod;

  assign ones_val = PW'(1) - (PW'(1) << AW) - (PW'(1) << BW);
  assign lo_prod  = (EA+EB)'(a_i[EA-1:0]) * (EA+EB)'(b_i[EB-1:0]);

  always_comb begin
    p_full_product_r1: assert (prod_o == PW'(a_i) * PW'(b_i));
    if (a_i == '0 || b_i == '0)
      p_zero_operand_r7: assert (prod_o == '0);
    if (a_i == '1 && b_i == '1)
      p_all_ones_r5: assert (prod_o == ones_val); // also R4
    if (EA == EB)
      p_low_passthru_r3: assert (prod_o[EB-1:0] == lo_prod[EB-1:0]);
  end
endmodule

bind split_mul_composer split_mul_chk #(.AW(AW), .BW(BW), .A0W(A0W), .B0W(B0W)) u_chk (
  .a_i(a_i), .b_i(b_i), .prod_o(prod_o)
);

// File: tb/sim_split_mul_composer.sv
`timescale 1ns/1ps
module sim_split_mul_composer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [15:0] a_r = '0;
  logic [15:0] b_r = '0;

  logic [31:0] y0;
  logic [27:0] y1;
  logic [25:0] y2;

  // equal split
  split_mul_composer #(.AW(16), .BW(16), .A0W(8), .B0W(8)) u0 (
    .a_i(a_r), .b_i(b_r), .prod_o(y0));
  // unequal split
  split_mul_composer #(.AW(16), .BW(12), .A0W(9), .B0W(5)) u1 (
    .a_i(a_r), .b_i(b_r[11:0]), .prod_o(y1));
  // swapped ports: EA=4, EB=7
  split_mul_composer #(.AW(10), .BW(16), .A0W(7), .B0W(4)) u2 (
    .a_i(a_r[9:0]), .b_i(b_r), .prod_o(y2));

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input string tag);
    longint ea0, ea1, ea2;
    @(posedge clk);
    a_r <= a;
    b_r <= b;
    @(negedge clk);
    ea0 = longint'(a) * longint'(b);
    ea1 = longint'(a) * longint'(b[11:0]);
    ea2 = longint'(a[9:0]) * longint'(b);
    chk({tag, " R1 R4 R8 eq"}, longint'(y0), ea0);
    chk({tag, " R1 R5 ne"}, longint'(y1), ea1);
    chk({tag, " R1 R6 swap"}, longint'(y2), ea2);
    chk({tag, " R3 low"}, longint'(y0[7:0]), (longint'(a[7:0]) * longint'(b[7:0])) % 256);
    if (a == 0 || b == 0) begin
      chk({tag, " R7 zero eq"}, longint'(y0), 0);
      chk({tag, " R7 zero ne"}, longint'(y1), 0);
    end
  endtask

  initial begin
    #(8*200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R7 reset-state zero", longint'(y0), 0);
    apply(16'h0000, 16'h0000, "zero");
    apply(16'h0000, 16'hffff, "zero_a");
    apply(16'hffff, 16'h0000, "zero_b");
    apply(16'hffff, 16'hffff, "ones");
    // split boundaries R2
    apply(16'h0100, 16'h0100, "R2 cut_eq");
    apply(16'h00ff, 16'h00ff, "R2 below_eq");
    apply(16'h0200, 16'h0020, "R2 cut_ne");
    apply(16'h01ff, 16'h001f, "R2 below_ne");
    apply(16'h0010, 16'h0080, "R2 cut_swap");
    apply(16'h000f, 16'h007f, "R2 below_swap");
    apply(16'h8000, 16'h8000, "msb");
    apply(16'haaaa, 16'h5555, "alt");
    for (int i = 0; i < 300; i++)
      apply(16'($urandom), 16'($urandom), "rand");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule